// File: doc/BRIEF.md
# Dual-Channel Lookup-Multiplier Systolic Cell

This block is one processing element of a linear systolic array that runs two convolutions side by side. Each cycle it takes one operand and one running partial sum for each of two channels, A and B, plus one sign tag per channel. It multiplies each operand by the same fixed coefficient and adds the product to that channel's partial sum, or subtracts it.

The multiplier has no hardware multiplier. A small table holds the coefficient times every pattern of half the operand bits. The even-indexed bits of the operand address one read port and the odd-indexed bits address the other. The odd-port word is weighted by a one-bit left shift, which is only wiring, and a single fast adder combines the two words into the full product.

The operands and tags pass through unchanged, so the next cell in the array receives them aligned with the updated partial sums. Operands are unsigned and partial sums are two's complement. Every output appears four clock cycles after the input that produced it, and the cell accepts a new input set every cycle.

Top module: `dual_lut_mac_cell`

## Requirements
- R1: While reset is low, every output of the cell is zero.
- R2: When sel_a_in is 0, ps_a_out equals ps_a_in + COEF·op_a_in, four cycles after the inputs are presented.
- R3: When sel_a_in is 1, ps_a_out equals ps_a_in − COEF·op_a_in, four cycles after the inputs are presented.
- R4: ps_b_out equals ps_b_in − COEF·op_b_in four cycles later when sel_b_in is 1, and ps_b_in + COEF·op_b_in when it is 0.
- R5: op_a_out and op_b_out repeat op_a_in and op_b_in unchanged, four cycles later.
- R6: sel_a_out and sel_b_out repeat sel_a_in and sel_b_in, four cycles later.
- R7: The table-based product equals COEF times the operand for every unsigned operand value, including 0 and the all-ones value.
- R8: Partial-sum arithmetic wraps modulo 2^ACC_W in two's complement.
- R9: sel_a_in affects only channel A and sel_b_in affects only channel B.
- R10: A new input set is accepted every cycle, and back-to-back sets produce back-to-back results with no interaction between them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_a_in | input | OP_W | Channel A operand (unsigned) |
| op_b_in | input | OP_W | Channel B operand (unsigned) |
| ps_a_in | input | ACC_W | Channel A incoming partial sum |
| ps_b_in | input | ACC_W | Channel B incoming partial sum |
| sel_a_in | input | 1 | Channel A subtract tag |
| sel_b_in | input | 1 | Channel B subtract tag |
| op_a_out | output | OP_W | Forwarded channel A operand |
| op_b_out | output | OP_W | Forwarded channel B operand |
| ps_a_out | output | ACC_W | Channel A updated partial sum |
| ps_b_out | output | ACC_W | Channel B updated partial sum |
| sel_a_out | output | 1 | Forwarded channel A tag |
| sel_b_out | output | 1 | Forwarded channel B tag |

## Verification
Every output is due exactly four rising edges after the input set that caused it: one capture stage, one table read, one product add and one accumulate stage. The bench drives inputs on falling edges. In the table walk it feeds one vector per cycle and compares the results for vector n on the falling edge where vector n+4 is driven, which also exercises full throughput. The directed tests hold their inputs and wait four falling edges before sampling. The reset checks sample while reset is held low.

// File: rtl/cell_pkg.sv
package cell_pkg;

   // Forwarded tag pair
   typedef struct packed {
      logic sel_a;
      logic sel_b;
   } tag_t;

   // Coefficient times the value whose bit 2j is bit j of pattern
   function automatic longint spread_mult(input int pattern, input int coef, input int half);
      longint e;
      e = 0;
      for (int j = 0; j < half; j++) begin
         if (pattern[j]) e += longint'(1) << (2 * j);
      end
      return longint'(coef) * e;
   endfunction

endpackage

// File: rtl/pipe_delay.sv
module pipe_delay #(
   parameter int W     = 1,
   parameter int DEPTH = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (DEPTH < 1) begin : g_bad_depth
      $error("pipe_delay: DEPTH must be at least 1");
   end

   if (DEPTH == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q <= '0;
         else        q <= d;
      end
   end else begin : g_chain
      logic [DEPTH-1:0][W-1:0] stg;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stg <= '0;
         else        stg <= {stg[DEPTH-2:0], d};
      end
      assign q = stg[DEPTH-1];
   end
endmodule

// File: rtl/lut_mult.sv
module lut_mult #(
   parameter int                        OP_W   = 8,
   parameter int                        COEF_W = 12,
   parameter logic signed [COEF_W-1:0]  COEF   = 12'sd1447,
   localparam int                       PW     = COEF_W + OP_W + 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [OP_W-1:0]      op,
   output logic signed [PW-1:0] prod
);
   localparam int HALF  = OP_W / 2;
   localparam int DEPTH = 1 << HALF;
   localparam int RW    = COEF_W + OP_W;

   logic [HALF-1:0]        ev_addr, od_addr;
   logic signed [RW-1:0]   tbl [DEPTH];
   logic signed [RW-1:0]   ev_q, od_q;

   // Split the operand into its even-indexed and odd-indexed bits
   for (genvar j = 0; j < HALF; j++) begin : g_split
      assign ev_addr[j] = op[2*j];
      assign od_addr[j] = op[2*j+1];
   end

   // Table contents computed at elaboration
   for (genvar g = 0; g < DEPTH; g++) begin : g_tbl
      assign tbl[g] = RW'(cell_pkg::spread_mult(g, int'(COEF), HALF));
   end

   // Stage: two parallel table reads
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ev_q <= '0;
         od_q <= '0;
      end else begin
         ev_q <= tbl[ev_addr];
         od_q <= tbl[od_addr];
      end
   end

   // Stage: fast combine, odd word weighted by a wired one-bit shift
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prod <= '0;
      else        prod <= PW'(ev_q) + (PW'(od_q) <<< 1);
   end

   logic [1:0] age;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        age <= '0;
      else if (age != 2) age <= age + 2'd1;
   end

   assert_lut_product_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (age == 2) |-> (prod == PW'(PW'(COEF) * PW'($signed({1'b0, $past(op, 2)})))));
endmodule

// File: rtl/sign_acc.sv
module sign_acc #(
   parameter int PW    = 22,
   parameter int ACC_W = 24
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    sub,
   input  logic signed [ACC_W-1:0] ps_in,
   input  logic signed [PW-1:0]    prod,
   output logic signed [ACC_W-1:0] ps_out
);
   logic signed [ACC_W-1:0] ext, term;

   assign ext  = ACC_W'(prod);
   assign term = sub ? (~ext + 1'b1) : ext;

   // Ripple-friendly accumulate stage; wraps modulo 2^ACC_W
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ps_out <= '0;
      else        ps_out <= ps_in + term;
   end
endmodule

// File: rtl/dual_lut_mac_cell.sv
module dual_lut_mac_cell #(
   parameter int                        OP_W   = 8,
   parameter int                        COEF_W = 12,
   parameter logic signed [COEF_W-1:0]  COEF   = 12'sd1447,
   parameter int                        ACC_W  = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [OP_W-1:0]  op_a_in,
   input  logic [OP_W-1:0]  op_b_in,
   input  logic [ACC_W-1:0] ps_a_in,
   input  logic [ACC_W-1:0] ps_b_in,
   input  logic             sel_a_in,
   input  logic             sel_b_in,
   output logic [OP_W-1:0]  op_a_out,
   output logic [OP_W-1:0]  op_b_out,
   output logic [ACC_W-1:0] ps_a_out,
   output logic [ACC_W-1:0] ps_b_out,
   output logic             sel_a_out,
   output logic             sel_b_out
);
   import cell_pkg::*;

   localparam int PW    = COEF_W + OP_W + 2;
   localparam int CAP_W = 2 * OP_W + 2 * ACC_W + 2;
   localparam int FWD_W = 2 * OP_W + 2;
   localparam int ACB_W = 2 * ACC_W + 2;

   if ((OP_W % 2) != 0 || OP_W < 2 || OP_W > 16) begin : g_bad_op
      $error("dual_lut_mac_cell: OP_W must be even and within 2..16");
   end
   if (ACC_W < PW) begin : g_bad_acc
      $error("dual_lut_mac_cell: ACC_W too narrow for the product");
   end

   // Stage 1: capture everything
   logic [OP_W-1:0]  op_s1 [2];
   logic [ACC_W-1:0] ps_s1 [2];
   tag_t             tag_s1;

   pipe_delay #(.W(CAP_W), .DEPTH(1)) u_cap (
      .clk(clk), .rst_n(rst_n),
      .d({op_a_in, op_b_in, ps_a_in, ps_b_in, sel_a_in, sel_b_in}),
      .q({op_s1[0], op_s1[1], ps_s1[0], ps_s1[1], tag_s1})
   );

   // Operands and tags to the next cell: three more stages
   tag_t tag_out;
   pipe_delay #(.W(FWD_W), .DEPTH(3)) u_fwd (
      .clk(clk), .rst_n(rst_n),
      .d({op_s1[0], op_s1[1], tag_s1}),
      .q({op_a_out, op_b_out, tag_out})
   );
   assign sel_a_out = tag_out.sel_a;
   assign sel_b_out = tag_out.sel_b;

   // Partial sums and tags wait two stages for the product
   logic [ACC_W-1:0] ps_s3 [2];
   tag_t             tag_s3;
   pipe_delay #(.W(ACB_W), .DEPTH(2)) u_acb (
      .clk(clk), .rst_n(rst_n),
      .d({ps_s1[0], ps_s1[1], tag_s1}),
      .q({ps_s3[0], ps_s3[1], tag_s3})
   );

   logic              sub_s3 [2];
   logic [ACC_W-1:0]  ps_o   [2];
   assign sub_s3[0] = tag_s3.sel_a;
   assign sub_s3[1] = tag_s3.sel_b;

   for (genvar ch = 0; ch < 2; ch++) begin : g_ch
      logic signed [PW-1:0]    prod;
      logic signed [ACC_W-1:0] acc;

      lut_mult #(.OP_W(OP_W), .COEF_W(COEF_W), .COEF(COEF)) u_mul (
         .clk(clk), .rst_n(rst_n), .op(op_s1[ch]), .prod(prod)
      );

      sign_acc #(.PW(PW), .ACC_W(ACC_W)) u_acc (
         .clk(clk), .rst_n(rst_n), .sub(sub_s3[ch]),
         .ps_in($signed(ps_s3[ch])), .prod(prod), .ps_out(acc)
      );
      assign ps_o[ch] = acc;
   end

   assign ps_a_out = ps_o[0];
   assign ps_b_out = ps_o[1];

   // Checks against the port-level definition
   function automatic logic [ACC_W-1:0] ref_mac(input logic [ACC_W-1:0] ps,
                                                input logic [OP_W-1:0]  op,
                                                input logic             sub);
      logic signed [ACC_W-1:0] p;
      p = ACC_W'(COEF) * ACC_W'($signed({1'b0, op}));
      return sub ? (ps - p) : (ps + p);
   endfunction

   logic [2:0] age;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        age <= '0;
      else if (age != 4) age <= age + 3'd1;
   end

   assert_chan_a_add_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (age == 4 && !$past(sel_a_in, 4)) |->
         (ps_a_out == ref_mac($past(ps_a_in, 4), $past(op_a_in, 4), 1'b0)));

   assert_chan_a_sub_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (age == 4 && $past(sel_a_in, 4)) |->
         (ps_a_out == ref_mac($past(ps_a_in, 4), $past(op_a_in, 4), 1'b1)));

   assert_chan_b_sign_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (age == 4) |->
         (ps_b_out == ref_mac($past(ps_b_in, 4), $past(op_b_in, 4), $past(sel_b_in, 4))));

   assert_pass_operands_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (age == 4) |-> (op_a_out == $past(op_a_in, 4) && op_b_out == $past(op_b_in, 4)));

   assert_pass_tags_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (age == 4) |-> (sel_a_out == $past(sel_a_in, 4) && sel_b_out == $past(sel_b_in, 4)));
endmodule

// File: tb/dual_lut_mac_cell_tb.sv
module dual_lut_mac_cell_tb_top;
   localparam time CLK_PERIOD = 10ns;
   localparam int  OPW  = 8;
   localparam int  ACW  = 24;
   localparam longint C = 1447;
   localparam longint MASK = (longint'(1) << ACW) - 1;

   typedef struct packed {
      logic [OPW-1:0] a;
      logic [OPW-1:0] b;
      logic [ACW-1:0] pa;
      logic [ACW-1:0] pb;
      logic           sb;
      logic           sa;
   } vec_t;

   localparam int NV = 10;
   localparam vec_t VT [NV] = '{
      '{8'd3,   8'd5,   24'd100,     24'd200,     1'b0, 1'b0},
      '{8'd255, 8'd0,   24'd0,       24'd0,       1'b0, 1'b1},
      '{8'd0,   8'd255, 24'hFFFFCE,  24'd7,       1'b1, 1'b0},
      '{8'hAA,  8'h55,  24'd1000,    24'd1000,    1'b1, 1'b1},
      '{8'd1,   8'd128, 24'd0,       24'd0,       1'b0, 1'b0},
      '{8'd200, 8'd17,  24'h7FFFFF,  24'h800000,  1'b0, 1'b1},
      '{8'd99,  8'd77,  24'd12345,   24'hFF0000,  1'b1, 1'b0},
      '{8'd64,  8'd2,   24'd0,       24'h000010,  1'b1, 1'b1},
      '{8'd255, 8'd255, 24'hFFFFFF,  24'd0,       1'b0, 1'b0},
      '{8'd13,  8'd250, 24'd500,     24'd500,     1'b0, 1'b1}
   };

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [OPW-1:0] op_a_in = '0, op_b_in = '0;
   logic [ACW-1:0] ps_a_in = '0, ps_b_in = '0;
   logic           sel_a_in = 1'b0, sel_b_in = 1'b0;
   logic [OPW-1:0] op_a_out, op_b_out;
   logic [ACW-1:0] ps_a_out, ps_b_out;
   logic           sel_a_out, sel_b_out;

   int total = 0;
   int bad   = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   dual_lut_mac_cell dut_i (
      .clk(clk), .rst_n(rst_n),
      .op_a_in(op_a_in), .op_b_in(op_b_in),
      .ps_a_in(ps_a_in), .ps_b_in(ps_b_in),
      .sel_a_in(sel_a_in), .sel_b_in(sel_b_in),
      .op_a_out(op_a_out), .op_b_out(op_b_out),
      .ps_a_out(ps_a_out), .ps_b_out(ps_b_out),
      .sel_a_out(sel_a_out), .sel_b_out(sel_b_out)
   );

   function automatic longint mac(input logic [ACW-1:0] ps, input logic [OPW-1:0] op,
                                  input logic sub);
      longint p;
      p = C * longint'(op);
      return sub ? ((longint'(ps) - p) & MASK) : ((longint'(ps) + p) & MASK);
   endfunction

   task automatic check(input string req, input longint act, input longint exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic drive(input vec_t v);
      op_a_in  = v.a;  op_b_in  = v.b;
      ps_a_in  = v.pa; ps_b_in  = v.pb;
      sel_a_in = v.sa; sel_b_in = v.sb;
   endtask

   task automatic check_vec(input vec_t v, input string extra);
      check($sformatf("%s %s", v.sa ? "R3" : "R2", extra), longint'(ps_a_out), mac(v.pa, v.a, v.sa));
      check($sformatf("R4 %s", extra), longint'(ps_b_out), mac(v.pb, v.b, v.sb));
      check($sformatf("R5 %s", extra), longint'({op_a_out, op_b_out}), longint'({v.a, v.b}));
      check($sformatf("R6 %s", extra), longint'({sel_a_out, sel_b_out}), longint'({v.sa, v.sb}));
   endtask

   task automatic check_zero(input string tag);
      check(tag, longint'(ps_a_out), 0);
      check(tag, longint'(ps_b_out), 0);
      check(tag, longint'({op_a_out, op_b_out, sel_a_out, sel_b_out}), 0);
   endtask

   // Hold one vector, wait the four-cycle latency, then check
   task automatic apply(input vec_t v, input string extra);
      @(negedge clk);
      drive(v);
      repeat (4) @(negedge clk);
      check_vec(v, extra);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      bad++;
      total++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check_zero("R1 initial reset");
      rst_n = 1'b1;

      // R10: one vector per cycle; results for vector s-4 are due now
      for (int s = 0; s < NV + 4; s++) begin
         @(negedge clk);
         if (s >= 4) check_vec(VT[s-4], $sformatf("R10 table %0d", s - 4));
         if (s < NV) drive(VT[s]);
         else        drive('0);
      end

      // R7: operand extremes
      apply('{8'd255, 8'd0, 24'd0, 24'd0, 1'b0, 1'b0}, "R7 max/zero");
      check("R7 product max", longint'(ps_a_out), C * 255);
      apply('{8'h80, 8'h01, 24'd0, 24'd0, 1'b0, 1'b0}, "R7 single bits");

      // R8: wrap in both directions
      apply('{8'd255, 8'd255, 24'h7FFFFF, 24'h800000, 1'b1, 1'b0}, "R8 wrap");
      check("R8 wrap up", longint'(ps_a_out), (longint'(24'h7FFFFF) + C * 255) & MASK);

      // R9: independent tags
      apply('{8'd10, 8'd10, 24'd50000, 24'd50000, 1'b1, 1'b0}, "R9 b-sub a-add");
      check("R9 channels differ", longint'(ps_a_out) - longint'(ps_b_out), 2 * C * 10);
      apply('{8'd10, 8'd10, 24'd50000, 24'd50000, 1'b0, 1'b1}, "R9 a-sub b-add");

      // R1: reset in mid-run clears outputs
      @(negedge clk);
      drive(VT[3]);
      repeat (2) @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check_zero("R1 mid-run reset");
      rst_n = 1'b1;
      apply(VT[6], "after reset");

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule